// File: doc/BRIEF.md
# Receive Carrier Jabber Watchdog

This block guards the receive side of an Ethernet MAC against a transmitter that never stops. It watches the carrier-sense input once per bit time, as marked by a one-cycle bit enable, and counts how long carrier has been continuously present. When a single carrier episode runs far past the longest legal frame, the block trips. It sets a sticky timeout status bit, which the surrounding MAC folds into its receive-error summary, and it raises a one-cycle interrupt request.

After a trip the watchdog is held and cannot trip again until the line has been quiet for a release window. The window length is chosen by a select input: a short window of 20 bit times or a long one of 44. Any reappearance of carrier during the window restarts the quiet measurement. A disable input prevents tripping. A synchronous reset or a software reset pulse clears the status, both run counters and the held state.

Top module: `rx_jabber_wd`

## Requirements
- R1: While `rst_n` is low at a clock edge, `wd_timeout` and `wd_irq` are low after that edge, and the block is armed.
- R2: A carrier episode shorter than 2048 bytes (16384 bit times) never sets `wd_timeout`.
- R3: With `wd_disable` low and the block armed, `wd_timeout` rises after the edge that samples the 18432nd consecutive bit time with carrier present (2304 bytes, inside the required 2048 to 2560 byte bound).
- R4: `wd_irq` is high for exactly one cycle per trip, in the same cycle that `wd_timeout` first shows the trip.
- R5: Only cycles with `bit_en` high count as bit times; in other cycles the `crs` value is ignored and neither advances nor breaks a run.
- R6: While `wd_disable` is high the watchdog never trips, however long carrier lasts.
- R7: Once tripped, the block does not trip again until re-armed; with `rel_long` low it re-arms on the 20th consecutive quiet bit time (inside 16 to 24).
- R8: With `rel_long` high, re-arming takes 44 consecutive quiet bit times (inside 40 to 48); 43 are not enough.
- R9: A bit time with carrier present during the release window restarts the quiet count from zero.
- R10: `wd_timeout` stays set until reset or a `soft_rst` pulse; `soft_rst` clears status, counters and the held state, and wins over a trip falling in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_rst | input | 1 | Synchronous software reset pulse, active high |
| bit_en | input | 1 | One-cycle strobe marking a receive bit time |
| crs | input | 1 | Receive carrier sense, sampled when `bit_en` is high |
| wd_disable | input | 1 | High blocks any trip |
| rel_long | input | 1 | Release window select: 0 = 20 bit times, 1 = 44 bit times |
| wd_timeout | output | 1 | Sticky watchdog timeout status |
| wd_irq | output | 1 | One-cycle interrupt request on each trip |

## Verification
The trip and the software reset are the two functions that can land on the same clock edge. The bench drives carrier for 18431 bit times after a clean restart and then raises `soft_rst` on exactly the cycle that carries the 18432nd carrier bit. The outcome is judged at the ports: `wd_timeout` and `wd_irq` must both stay low after that edge and on the following bit, which shows that the clear took precedence and the run counter restarted instead of tripping one bit late.

// File: rtl/rjw_pkg.sv
package rjw_pkg;

  localparam int unsigned BITS_PER_BYTE = 8;

  typedef enum logic {
    ST_ARMED = 1'b0,
    ST_HELD  = 1'b1
  } wd_state_e;

  // Carrier limit expressed in bit times.
  function automatic int unsigned bytes_to_bits(input int unsigned nbytes);
    return nbytes * BITS_PER_BYTE;
  endfunction

  // Quiet window selected by the release select.
  function automatic int unsigned pick_window(input logic long_sel,
                                              input int unsigned short_w,
                                              input int unsigned long_w);
    return long_sel ? long_w : short_w;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rjw_run_cnt.sv
// Counts consecutive bit times whose carrier level equals COUNT_HIGH,
// saturating at LIMIT. Cycles without bit_en leave the count untouched.
module rjw_run_cnt #(
  parameter int unsigned LIMIT      = 8,
  parameter bit          COUNT_HIGH = 1'b1,
  parameter int unsigned W          = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         bit_en,
  input  logic         level,
  output logic [W-1:0] run
);

  localparam logic [W-1:0] CAP = W'(LIMIT);

  logic hit;
  assign hit = (level == COUNT_HIGH);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      run <= '0;
    end else if (bit_en) begin
      if (!hit) begin
        run <= '0;
      end else if (run != CAP) begin
        run <= run + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rjw_trip_ctl.sv
// Armed / held state, sticky status and the registered interrupt pulse.
module rjw_trip_ctl
  import rjw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic trip_evt,
  input  logic rel_evt,
  output logic held,
  output logic status,
  output logic irq
);

  wd_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      state  <= ST_ARMED;
      status <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= trip_evt;
      if (trip_evt) begin
        state  <= ST_HELD;
        status <= 1'b1;
      end else if (rel_evt) begin
        state <= ST_ARMED;
      end
    end
  end

  assign held = (state == ST_HELD);

endmodule

// File: rtl/rx_jabber_wd.sv
module rx_jabber_wd
  import rjw_pkg::*;
#(
  parameter int unsigned TRIP_BYTES     = 2304,
  parameter int unsigned REL_SHORT_BITS = 20,
  parameter int unsigned REL_LONG_BITS  = 44
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic bit_en,
  input  logic crs,
  input  logic wd_disable,
  input  logic rel_long,
  output logic wd_timeout,
  output logic wd_irq
);

  localparam int unsigned TRIP_BITS = bytes_to_bits(TRIP_BYTES);
  localparam int unsigned QUIET_CAP = max_u(REL_SHORT_BITS, REL_LONG_BITS);
  localparam int unsigned ACT_W     = $clog2(TRIP_BITS + 1);
  localparam int unsigned QUIET_W   = $clog2(QUIET_CAP + 1);
  localparam logic [ACT_W-1:0] ACT_LAST = ACT_W'(TRIP_BITS - 1);

  logic [ACT_W-1:0]   act_run;
  logic [QUIET_W-1:0] quiet_run;
  logic [QUIET_W-1:0] rel_last;
  logic               held;
  logic               run_at_limit;
  logic               quiet_at_window;
  logic               trip_evt;
  logic               rel_evt;

  // Consecutive carrier bit times.
  rjw_run_cnt #(
    .LIMIT      (TRIP_BITS),
    .COUNT_HIGH (1'b1),
    .W          (ACT_W)
  ) i_act_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (soft_rst),
    .bit_en (bit_en),
    .level  (crs),
    .run    (act_run)
  );

  // Consecutive quiet bit times; restarts whenever carrier returns.
  rjw_run_cnt #(
    .LIMIT      (QUIET_CAP),
    .COUNT_HIGH (1'b0),
    .W          (QUIET_W)
  ) i_quiet_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (soft_rst),
    .bit_en (bit_en),
    .level  (crs),
    .run    (quiet_run)
  );

  always_comb begin
    rel_last        = QUIET_W'(pick_window(rel_long, REL_SHORT_BITS, REL_LONG_BITS) - 1);
    run_at_limit    = (act_run == ACT_LAST);
    quiet_at_window = (quiet_run == rel_last);
    trip_evt        = bit_en && crs && !wd_disable && !held && run_at_limit;
    rel_evt         = bit_en && !crs && held && quiet_at_window;
  end

  rjw_trip_ctl i_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (soft_rst),
    .trip_evt (trip_evt),
    .rel_evt  (rel_evt),
    .held     (held),
    .status   (wd_timeout),
    .irq      (wd_irq)
  );

endmodule

// File: rtl/rx_jabber_wd_chk.sv
module rx_jabber_wd_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic bit_en,
  input logic crs,
  input logic wd_disable,
  input logic wd_timeout,
  input logic wd_irq,
  input logic trip_evt,
  input logic rel_evt,
  input logic held
);

  localparam logic [15:0] PASS_RUN = 16'(2048 * 8);
  localparam logic [15:0] FAIL_RUN = 16'(2560 * 8);
  localparam logic [7:0]  WIN_MIN  = 8'd16;
  localparam logic [7:0]  WIN_MAX  = 8'd48;

  // Independent run models, updated on the same edges as the design.
  logic [15:0] chk_run;
  logic [7:0]  chk_quiet;

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      chk_run   <= '0;
      chk_quiet <= '0;
    end else if (bit_en) begin
      chk_run   <= crs  ? ((chk_run   == 16'hFFFF) ? chk_run   : chk_run + 16'd1) : 16'd0;
      chk_quiet <= !crs ? ((chk_quiet == 8'hFF)    ? chk_quiet : chk_quiet + 8'd1) : 8'd0;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !wd_timeout && !wd_irq);

  p_pass_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_timeout) |-> (chk_run >= PASS_RUN) && (chk_run <= FAIL_RUN));

  p_trip_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trip_evt && !soft_rst |=> wd_timeout && wd_irq && held);

  p_irq_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |=> !wd_irq);

  p_irq_with_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |-> wd_timeout);

  p_rise_on_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_timeout) |-> $past(bit_en) && $past(crs));

  p_disabled_no_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_timeout) |-> !$past(wd_disable));

  p_release_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held) && !$past(soft_rst) |-> (chk_quiet >= WIN_MIN) && (chk_quiet <= WIN_MAX));

  p_release_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt && !soft_rst |=> !held);

  p_status_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    wd_timeout |=> wd_timeout);

endmodule

bind rx_jabber_wd rx_jabber_wd_chk i_rx_jabber_wd_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .bit_en     (bit_en),
  .crs        (crs),
  .wd_disable (wd_disable),
  .wd_timeout (wd_timeout),
  .wd_irq     (wd_irq),
  .trip_evt   (trip_evt),
  .rel_evt    (rel_evt),
  .held       (held)
);

// File: tb/test_rx_jabber_wd.sv
module test_rx_jabber_wd;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 195000;
  localparam int TRIP = 2304 * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic bit_en = 1'b0;
  logic crs = 1'b0;
  logic wd_disable = 1'b0;
  logic rel_long = 1'b0;
  logic wd_timeout;
  logic wd_irq;

  int n_checks = 0;
  int n_errors = 0;
  int irq_seen = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_jabber_wd i_rx_jabber_wd (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .bit_en     (bit_en),
    .crs        (crs),
    .wd_disable (wd_disable),
    .rel_long   (rel_long),
    .wd_timeout (wd_timeout),
    .wd_irq     (wd_irq)
  );

  typedef struct packed {
    logic        crs;
    logic        rel;
    logic [15:0] nbits;
    logic [1:0]  irqs;
    logic        stat;
  } seg_t;

  // Segments walked from a fresh reset with bit_en high every cycle.
  localparam seg_t SEGS [13] = '{
    '{1'b1, 1'b0, 16'd18431, 2'd0, 1'b0},  // R2: just below trip
    '{1'b1, 1'b0, 16'd1,     2'd1, 1'b1},  // R3 R4: 18432nd bit trips
    '{1'b1, 1'b0, 16'd200,   2'd0, 1'b1},  // R4: no second pulse
    '{1'b0, 1'b0, 16'd19,    2'd0, 1'b1},  // R7: 19 quiet bits
    '{1'b1, 1'b0, 16'd5,     2'd0, 1'b1},  // R9: carrier restarts window
    '{1'b0, 1'b0, 16'd19,    2'd0, 1'b1},  // R9: 19 again, still held
    '{1'b1, 1'b0, 16'd18500, 2'd0, 1'b1},  // R7 R9: held, no trip
    '{1'b0, 1'b0, 16'd20,    2'd0, 1'b1},  // R7: 20 quiet bits re-arm
    '{1'b1, 1'b0, 16'd18432, 2'd1, 1'b1},  // R7: trips again
    '{1'b0, 1'b1, 16'd43,    2'd0, 1'b1},  // R8: 43 quiet bits
    '{1'b1, 1'b1, 16'd18500, 2'd0, 1'b1},  // R8: not re-armed
    '{1'b0, 1'b1, 16'd44,    2'd0, 1'b1},  // R8: 44 quiet bits re-arm
    '{1'b1, 1'b1, 16'd18432, 2'd1, 1'b1}   // R8: trips again
  };

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive n cycles with the given inputs; count interrupt pulses seen.
  task automatic run_bits(input int n, input logic c, input logic be,
                          input logic dis, input logic rel, input logic sr);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      crs        = c;
      bit_en     = be;
      wd_disable = dis;
      rel_long   = rel;
      soft_rst   = sr;
      @(posedge clk);
      #1;
      if (wd_irq) irq_seen++;
    end
    @(negedge clk);
    soft_rst = 1'b0;
    bit_en   = 1'b0;
  endtask

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check("R1 status in reset", int'(wd_timeout), 0);
    check("R1 irq in reset", int'(wd_irq), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table of segments: R2 R3 R4 R7 R8 R9
    for (int i = 0; i < 13; i++) begin
      irq_seen = 0;
      run_bits(int'(SEGS[i].nbits), SEGS[i].crs, 1'b1, 1'b0, SEGS[i].rel, 1'b0);
      check($sformatf("R3/R4/R7/R8/R9 seg %0d irq pulses", i), irq_seen, int'(SEGS[i].irqs));
      check($sformatf("R2/R3/R10 seg %0d status", i), int'(wd_timeout), int'(SEGS[i].stat));
    end

    // R10: software reset clears sticky status
    irq_seen = 0;
    run_bits(1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R10 status after soft reset", int'(wd_timeout), 0);
    check("R10 irq after soft reset", int'(wd_irq), 0);

    // R6: disabled watchdog never trips
    irq_seen = 0;
    run_bits(20000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R6 status while disabled", int'(wd_timeout), 0);
    check("R6 irq while disabled", irq_seen, 0);
    run_bits(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

    // R5: cycles without bit_en ignore crs (low here) and do not break the run
    irq_seen = 0;
    run_bits(10000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    run_bits(300, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_bits(TRIP - 10001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R5 no trip one bit early", int'(wd_timeout), 0);
    run_bits(1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R5 trip on counted bit", int'(wd_timeout), 1);
    check("R5 one irq", irq_seen, 1);

    // R10: soft reset on the trip cycle wins
    run_bits(1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    irq_seen = 0;
    run_bits(TRIP - 1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    run_bits(1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R10 status when soft reset meets trip", int'(wd_timeout), 0);
    run_bits(1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R10 no late trip after clear", int'(wd_timeout), 0);
    check("R10 no irq at collision", irq_seen, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog (all requirements): actual=hung expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule